// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Extension

This block is the integer execute stage of a load/store RISC pipeline. Each accepted cycle it takes two 32-bit register operands, a 16-bit immediate, a 5-bit shift field, an operation code and a constant-select flag. It produces one 32-bit result. The supported work covers add and subtract (trapping and wrapping forms), four bitwise functions, signed and unsigned set-less-than, shifts by a constant or by a register amount, and loading the upper half of a word from the immediate.

How the immediate is widened depends on the class of the operation, not on whether the operation is signed. All arithmetic and compare operations sign extend it, including the wrapping add and the unsigned compare. The bitwise operations zero extend it. Only the trapping add and subtract can report signed overflow. When they do, a write-inhibit output tells the register file to keep the old destination value.

The result, the overflow flag and the write-inhibit are registered once. They appear on the clock edge after the operation is presented with `in_valid` high.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes are ADD_TRAP=0, ADD_WRAP=1, SUB_TRAP=2, SUB_WRAP=3. The result is the 32-bit sum or difference modulo 2^32, where the second operand is `opnd_b`, or the extended immediate when `use_const`=1.
- R2: `ovf_trap` is 1 only for ADD_TRAP and SUB_TRAP, and only when the two's-complement result overflows. ADD_WRAP and SUB_WRAP never raise it on the same operands.
- R3: Bitwise, compare, shift and upper-load operations (codes 4 to 13) never raise `ovf_trap`.
- R4: With `use_const`=1, codes 0, 1, 2, 3, 8 and 9 take `imm16` sign extended to 32 bits. This includes ADD_WRAP and the unsigned compare.
- R5: With `use_const`=1, AND=4, OR=5 and XOR=6 take `imm16` zero extended to 32 bits.
- R6: LT_SIGNED=8 gives 1 when A < B as two's complement, otherwise 0. LT_UNSIGNED=9 compares the same way as natural numbers. Bits 31:1 of the result are 0.
- R7: SHL=10 and SHR=11 shift `opnd_b` and fill with zeros. SHRA=12 fills with copies of bit 31. With `use_const`=1 the amount is `shamt`.
- R8: With `use_const`=0, a shift takes its amount from bits 4:0 of `opnd_a`, and the upper bits of `opnd_a` have no effect.
- R9: UPPER=13 returns `imm16` in bits 31:16 and zeros in bits 15:0.
- R10: NOR=7 returns the bitwise complement of (A OR B).
- R11: `wr_inhibit` is 1 exactly when a valid output carries `ovf_trap`=1.
- R12: Outputs appear one cycle after `in_valid`. `out_valid` follows `in_valid` by one cycle. Reset clears `out_valid`, `result`, `ovf_trap` and `wr_inhibit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 4 | Operation code |
| use_const | input | 1 | Use the immediate (or `shamt` for shifts) as the second operand |
| opnd_a | input | 32 | First register operand; supplies the amount for variable shifts |
| opnd_b | input | 32 | Second register operand; the value that shifts act on |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_inhibit | output | 1 | Block the destination register write |

## Verification
A fault in how the immediate is widened, or in which amount source a shift uses, shows up as a wrong `result` on the first valid output after the offending operation. That output is exactly one cycle after it is presented. A fault in the overflow gating shows as `ovf_trap` and `wr_inhibit` set on a wrapping or bitwise operation, or missing on a trapping one, in that same cycle. The stimulus therefore pairs each trapping operation with its wrapping twin on identical operands. It also uses operands at the sign boundary, so that sign versus zero extension, and signed versus unsigned ordering, give different answers.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_TRAP = 4'd0,
    OP_ADD_WRAP = 4'd1,
    OP_SUB_TRAP = 4'd2,
    OP_SUB_WRAP = 4'd3,
    OP_AND      = 4'd4,
    OP_OR       = 4'd5,
    OP_XOR      = 4'd6,
    OP_NOR      = 4'd7,
    OP_LT_S     = 4'd8,
    OP_LT_U     = 4'd9,
    OP_SHL      = 4'd10,
    OP_SHR      = 4'd11,
    OP_SHRA     = 4'd12,
    OP_UPPER    = 4'd13
  } op_e;

  function automatic logic op_traps(input logic [OP_W-1:0] op);
    return (op == OP_ADD_TRAP) || (op == OP_SUB_TRAP);
  endfunction

  function automatic logic op_signext(input logic [OP_W-1:0] op);
    return (op <= OP_SUB_WRAP) || (op == OP_LT_S) || (op == OP_LT_U);
  endfunction

  function automatic logic op_is_shift(input logic [OP_W-1:0] op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SHRA);
  endfunction
endpackage

// File: rtl/imm_widen.sv
module imm_widen #(
  parameter int IMM_W = 16,
  parameter int XLEN  = 32
) (
  input  logic [IMM_W-1:0] imm_in,
  input  logic             sign_mode,
  output logic [XLEN-1:0]  imm_out
);
  localparam int PAD_W = XLEN - IMM_W;

  logic pad_bit;

  always_comb begin
    pad_bit = sign_mode & imm_in[IMM_W-1];
    imm_out = {{PAD_W{pad_bit}}, imm_in};
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic            do_sub,
  output logic [XLEN-1:0] total,
  output logic            sgn_ovf
);
  logic [XLEN-1:0] rhs_eff;
  logic [XLEN:0]   wide;

  always_comb begin
    rhs_eff = do_sub ? ~rhs : rhs;
    wide    = {1'b0, lhs} + {1'b0, rhs_eff} + {{XLEN{1'b0}}, do_sub};
    total   = wide[XLEN-1:0];
    // overflow when both addends share a sign that the sum does not
    sgn_ovf = (lhs[XLEN-1] == rhs_eff[XLEN-1]) && (total[XLEN-1] != lhs[XLEN-1]);
  end
endmodule

// File: rtl/logic_core.sv
module logic_core #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic [1:0]      fn,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (fn)
      2'd0:    y = lhs & rhs;
      2'd1:    y = lhs | rhs;
      2'd2:    y = lhs ^ rhs;
      default: y = ~(lhs | rhs);
    endcase
  end
endmodule

// File: rtl/barrel_shift.sv
module barrel_shift #(
  parameter int XLEN = 32,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val,
  input  logic [SH_W-1:0] amt,
  input  logic            go_right,
  input  logic            arith,
  output logic [XLEN-1:0] y
);
  logic            fill;
  logic [XLEN-1:0] stage [0:SH_W];

  assign fill     = arith & val[XLEN-1];
  assign stage[0] = val;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [XLEN-1:0] moved;
    always_comb begin
      if (go_right) moved = {{D{fill}}, stage[i][XLEN-1:D]};
      else          moved = {stage[i][XLEN-1-D:0], {D{1'b0}}};
    end
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign y = stage[SH_W];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_sel,
  input  logic             use_const,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [SH_W-1:0]  shamt,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             ovf_trap,
  output logic             wr_inhibit
);
  localparam int LOW_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_x, b_eff, sum_y, logic_y, shift_y, res_n;
  logic            sgn_mode, do_sub, raw_ovf, ovf_n, lt_s, lt_u;
  logic [SH_W-1:0] sh_amt;

  assign sgn_mode = op_signext(op_sel);
  assign do_sub   = (op_sel == OP_SUB_TRAP) || (op_sel == OP_SUB_WRAP);
  assign b_eff    = (use_const && !op_is_shift(op_sel)) ? imm_x : opnd_b;
  assign sh_amt   = use_const ? shamt : opnd_a[SH_W-1:0];

  imm_widen #(.IMM_W(IMM_W), .XLEN(XLEN)) u_widen (
    .imm_in(imm16), .sign_mode(sgn_mode), .imm_out(imm_x)
  );

  addsub_core #(.XLEN(XLEN)) u_addsub (
    .lhs(opnd_a), .rhs(b_eff), .do_sub(do_sub), .total(sum_y), .sgn_ovf(raw_ovf)
  );

  logic_core #(.XLEN(XLEN)) u_logic (
    .lhs(opnd_a), .rhs(b_eff), .fn(op_sel[1:0]), .y(logic_y)
  );

  barrel_shift #(.XLEN(XLEN)) u_shift (
    .val(opnd_b), .amt(sh_amt), .go_right(op_sel != OP_SHL),
    .arith(op_sel == OP_SHRA), .y(shift_y)
  );

  always_comb begin
    lt_s = $signed(opnd_a) < $signed(b_eff);
    lt_u = opnd_a < b_eff;
  end

  always_comb begin
    res_n = '0;
    unique case (op_sel)
      OP_ADD_TRAP, OP_ADD_WRAP, OP_SUB_TRAP, OP_SUB_WRAP: res_n = sum_y;
      OP_AND, OP_OR, OP_XOR, OP_NOR:                      res_n = logic_y;
      OP_LT_S:  res_n = {{(XLEN-1){1'b0}}, lt_s};
      OP_LT_U:  res_n = {{(XLEN-1){1'b0}}, lt_u};
      OP_SHL, OP_SHR, OP_SHRA:                            res_n = shift_y;
      OP_UPPER: res_n = {imm16, {LOW_W{1'b0}}};
      default:  res_n = '0;
    endcase
    ovf_n = op_traps(op_sel) & raw_ovf;
  end

  // output stage: next-state and register processes
  logic            vld_q, ovf_q, vld_d, ovf_d;
  logic [XLEN-1:0] res_q, res_d;
  logic [OP_W-1:0] op_q, op_d;

  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? res_n  : res_q;
    ovf_d = in_valid ? ovf_n  : ovf_q;
    op_d  = in_valid ? op_sel : op_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ovf_q <= 1'b0;
      op_q  <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      ovf_q <= ovf_d;
      op_q  <= op_d;
    end
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign ovf_trap   = vld_q & ovf_q;
  assign wr_inhibit = vld_q & ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !op_traps(op_q)) |-> !ovf_trap); // R3
  AST_LT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_q == OP_LT_S || op_q == OP_LT_U)) |-> (result[XLEN-1:1] == '0)); // R6
  AST_UPPER_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_UPPER) |-> (result[LOW_W-1:0] == '0)); // R9
  AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_inhibit); // R11
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  logic        clk, rst_n, in_valid, use_const;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b, result;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic        out_valid, ovf_trap, wr_inhibit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] r;
    logic        v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .use_const(use_const), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16),
    .shamt(shamt), .out_valid(out_valid), .result(result),
    .ovf_trap(ovf_trap), .wr_inhibit(wr_inhibit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh, input logic uc);
    logic [31:0] bs, bz, r;
    logic [4:0]  amt;
    logic        v;
    bs  = uc ? {{16{imm[15]}}, imm} : b;
    bz  = uc ? {16'h0, imm} : b;
    amt = uc ? sh : a[4:0];
    v   = 1'b0;
    r   = 32'h0;
    case (op)
      4'd0: begin r = a + bs; v = (a[31] == bs[31]) && (r[31] != a[31]); end
      4'd1: r = a + bs;
      4'd2: begin r = a - bs; v = (a[31] != bs[31]) && (r[31] != a[31]); end
      4'd3: r = a - bs;
      4'd4: r = a & bz;
      4'd5: r = a | bz;
      4'd6: r = a ^ bz;
      4'd7: r = ~(a | bz);
      4'd8: r = {31'h0, $signed(a) < $signed(bs)};
      4'd9: r = {31'h0, a < bs};
      4'd10: r = b << amt;
      4'd11: r = b >> amt;
      4'd12: r = $unsigned($signed(b) >>> amt);
      4'd13: r = {imm, 16'h0};
      default: r = 32'h0;
    endcase
    return {v, r};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] imm, input logic [4:0] sh, input logic uc, input string tag);
    logic [32:0] m;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    imm16 = imm; shamt = sh; use_const = uc;
    m = model(op, a, b, imm, sh, uc);
    e.r = m[31:0]; e.v = m[32]; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares the output stage one cycle after each pushed item
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R12 unexpected out_valid", 32'(out_valid), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(result === e.r, {e.tag, " result"}, result, e.r);
          check(ovf_trap === e.v, {e.tag, " ovf_trap R2"}, 32'(ovf_trap), 32'(e.v));
          check(wr_inhibit === e.v, {e.tag, " wr_inhibit R11"}, 32'(wr_inhibit), 32'(e.v));
        end
      end else if (sb.size() != 0) begin
        check(1'b0, "R12 missing out_valid", 32'(out_valid), 32'h1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL R12 watchdog actual=hang expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; use_const = 1'b0;
    opnd_a = '0; opnd_b = '0; imm16 = '0; shamt = '0;
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 0 && result == 0 && ovf_trap == 0 && wr_inhibit == 0,
          "R12 reset state", {result[31:1], out_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 arithmetic, R2 trap vs wrap twins
    drive(4'd1, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R1 add wrap carry");
    drive(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R2 add trap ovf");
    drive(4'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R2 add wrap no ovf");
    drive(4'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0, "R2 sub trap ovf");
    drive(4'd3, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0, "R2 sub wrap no ovf");
    drive(4'd2, 32'h0000_0005, 32'h9, 16'h0, 5'd0, 1'b0, "R1 sub trap no ovf");
    drive(4'd0, 32'h8000_0000, 32'h0, 16'h8000, 5'd0, 1'b1, "R2 addi trap neg ovf");
    // R4 sign extension
    drive(4'd1, 32'h0000_0010, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R4 addi wrap signext");
    drive(4'd9, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R4 ltu imm signext");
    drive(4'd8, 32'h0000_0000, 32'h0, 16'h8000, 5'd0, 1'b1, "R4 lts imm signext");
    // R5 zero extension
    drive(4'd4, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R5 andi zeroext");
    drive(4'd5, 32'h1234_0000, 32'h0, 16'h8001, 5'd0, 1'b1, "R5 ori zeroext");
    drive(4'd6, 32'hF0F0_F0F0, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R5 xori zeroext");
    // R3 logic ops with overflow-prone operands
    drive(4'd5, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 5'd0, 1'b0, "R3 or no ovf");
    drive(4'd10, 32'h0, 32'h7FFF_FFFF, 16'h0, 5'd1, 1'b1, "R3 shl no ovf");
    // R10 nor
    drive(4'd7, 32'h0F0F_0000, 32'h00F0_00FF, 16'h0, 5'd0, 1'b0, "R10 nor reg");
    // R6 compares
    drive(4'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R6 lts minus one");
    drive(4'd9, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R6 ltu all ones");
    drive(4'd8, 32'h2, 32'h1, 16'h0, 5'd0, 1'b0, "R6 lts false");
    // R7 constant shifts
    drive(4'd10, 32'h0, 32'h8000_0001, 16'h0, 5'd4, 1'b1, "R7 shl const");
    drive(4'd11, 32'h0, 32'h8000_0000, 16'h0, 5'd31, 1'b1, "R7 shr const");
    drive(4'd12, 32'h0, 32'h8000_0010, 16'h0, 5'd4, 1'b1, "R7 shra const");
    drive(4'd12, 32'h0, 32'h4000_0000, 16'h0, 5'd30, 1'b1, "R7 shra positive");
    // R8 variable shifts, upper bits of amount register ignored
    drive(4'd10, 32'hFFFF_FFE5, 32'h0000_0003, 16'h0, 5'd0, 1'b0, "R8 shl variable");
    drive(4'd12, 32'h0000_0128, 32'hF000_0000, 16'h0, 5'd1, 1'b0, "R8 shra variable");
    drive(4'd11, 32'h0000_0020, 32'hDEAD_BEEF, 16'h0, 5'd3, 1'b0, "R8 shr amount zero");
    // R9 upper load
    drive(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 5'd0, 1'b1, "R9 upper");
    drive(4'd13, 32'h0, 32'h0, 16'h8000, 5'd0, 1'b0, "R9 upper no const");

    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && wr_inhibit == 1'b0, "R12 idle after drain",
          {30'h0, out_valid, wr_inhibit}, 32'h0);
    check(sb.size() == 0, "R12 scoreboard drained", 32'(sb.size()), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule